// File: doc/BRIEF.md
# Timer Fault and Park Controller

This block watches an external fault line on behalf of a PWM timer and, when told to, replaces the timer's PWM outputs with fixed safe levels. It holds a small free-running up counter with a run bit. A two-bit fault mode selects one of three reactions to an active fault: halt the counter at once, let it run to zero and halt there, or only raise a flag. The fault flag is sticky. Software clears it with a one-cycle clear strobe.

Park forcing can be tied to the fault flag, to a debug-halt input, or to either of them. While park is active, every PWM output and every complementary output takes the level held for it in a six-bit park-level vector. Otherwise the incoming PWM signals pass straight through. The fault line goes through a two-flop synchronizer. That synchronizer only advances while the counter runs.

Top module: `fault_park_top`

## Requirements
- R1: After reset, runMode is 0, count is 0 and faultFlag is 0. With dbgHalt low, pwmOut equals pwmIn and pwmCompOut equals pwmCompIn.
- R2: The fault line is level sensitive. With faultActLow=0 it is active when high, and with faultActLow=1 it is active when low. It passes through a two-flop synchronizer. A fault present before clock edge k is acted on at edge k+2. faultCtl is encoded as 0 = ignore, 1 = immediate stop, 2 = stop at zero, 3 = flag only. faultFlag is set at an edge where runMode=1, faultCtl is not 0 and the synchronized fault is active.
- R3: A one-cycle flagClr pulse clears faultFlag at the next edge. If a flag set occurs at the same edge, the set wins and the flag stays 1.
- R4: In immediate mode (faultCtl=1), an active synchronized fault clears runMode at the next edge. runMode stays 0 until a write with modeWrEn=1 and modeWrData=1. A software write takes priority over the hardware clear at the same edge.
- R5: While runMode=0, the synchronizer holds its state, the count holds its value and faultFlag cannot be set. A cleared flag therefore stays 0 whatever the fault line does.
- R6: In stop-at-zero mode (faultCtl=2), while faultFlag or the synchronized fault is active, the counter holds once it reaches 0. Clearing the flag while the fault line is inactive lets counting resume. A flag cleared before the count reaches 0 lets the counter pass through 0.
- R7: In flag-only mode (faultCtl=3), a fault sets faultFlag but leaves runMode and counting untouched.
- R8: parkCtl is encoded as 0 = off, 1 = park while faultFlag is set, 2 = park while dbgHalt is high, 3 = park on either. parkActive reports the resulting state.
- R9: While parked, the outputs take their levels from parkLevels. Bit 0 drives output 0, bit 1 drives complementary 0, bit 2 drives output 1, bit 3 drives complementary 1, bit 4 drives output 2 and bit 5 drives complementary 2. A bit value of 1 means high.
- R10: While runMode=1 and no stop-at-zero hold applies, count rises by one per clock and wraps from 2^CNT_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWrEn | input | 1 | Write strobe for the run bit |
| modeWrData | input | 1 | Run bit value written on modeWrEn |
| faultCtl | input | 2 | Fault reaction select |
| faultActLow | input | 1 | Fault polarity, 1 means active low |
| flagClr | input | 1 | One-cycle clear strobe for faultFlag |
| parkCtl | input | 2 | Park trigger select |
| parkLevels | input | 2*NUM_CH | Forced output levels while parked |
| faultIn | input | 1 | Asynchronous fault line |
| dbgHalt | input | 1 | Debug-halt indication |
| pwmIn | input | NUM_CH | Incoming PWM signals |
| pwmCompIn | input | NUM_CH | Incoming complementary PWM signals |
| pwmOut | output | NUM_CH | PWM outputs after park forcing |
| pwmCompOut | output | NUM_CH | Complementary outputs after park forcing |
| runMode | output | 1 | Counter run bit |
| count | output | CNT_W | Counter value |
| faultFlag | output | 1 | Raw fault flag |
| parkActive | output | 1 | High while outputs are forced |

## Verification
The bench builds the block with CNT_W=4 and NUM_CH=3. A 16-value counter wraps within a few cycles, so the stop-at-zero hold and its cancellation, both of which depend on the count reaching 0, can each be reached several times in a short run. Three channels give every park-level bit its own position to check, using a pattern that differs from the pass-through inputs on each output.

// File: rtl/fp_pkg.sv
package fp_pkg;

  typedef enum logic [1:0] {
    FLT_IGNORE   = 2'd0,
    FLT_IMMED    = 2'd1,
    FLT_AT_ZERO  = 2'd2,
    FLT_FLAGONLY = 2'd3
  } faultMode_t;

  typedef enum logic [1:0] {
    PRK_OFF   = 2'd0,
    PRK_FAULT = 2'd1,
    PRK_DEBUG = 2'd2,
    PRK_ANY   = 2'd3
  } parkMode_t;

  typedef struct packed {
    logic syncEn;
    logic cntEn;
    logic parkSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/fp_datapath.sv
module fp_datapath
  import fp_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic                  faultIn,
  input  logic                  faultActLow,
  input  logic [NUM_CH-1:0]     pwmIn,
  input  logic [NUM_CH-1:0]     pwmCompIn,
  input  logic [2*NUM_CH-1:0]   parkLevels,
  output logic                  faultAct,
  output logic                  cntZero,
  output logic [CNT_W-1:0]      count,
  output logic [NUM_CH-1:0]     pwmOut,
  output logic [NUM_CH-1:0]     pwmCompOut
);

  localparam int SYNC_DEPTH = 2;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [SYNC_DEPTH-1:0] syncQ;
  logic                  faultNorm;

  // Polarity is folded in before the first flop so reset means "inactive".
  assign faultNorm = faultIn ^ faultActLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else if (strobe.syncEn) begin
      syncQ <= {syncQ[SYNC_DEPTH-2:0], faultNorm};
    end
  end

  assign faultAct = syncQ[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.cntEn) begin
      count <= count + CNT_ONE;
    end
  end

  assign cntZero = (count == '0);

  // One forcing mux per channel pair.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_comb begin
      if (strobe.parkSel) begin
        pwmOut[ch]     = parkLevels[2*ch];
        pwmCompOut[ch] = parkLevels[2*ch+1];
      end else begin
        pwmOut[ch]     = pwmIn[ch];
        pwmCompOut[ch] = pwmCompIn[ch];
      end
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntEn |=> count == $past(count) + CNT_ONE);  // R10
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cntEn |=> $stable(count));  // R5
  AST_SYNC_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.syncEn |=> $stable(faultAct));  // R5

endmodule

// File: rtl/fp_control.sv
module fp_control
  import fp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeWrEn,
  input  logic        modeWrData,
  input  faultMode_t  faultMode,
  input  parkMode_t   parkMode,
  input  logic        flagClr,
  input  logic        dbgHalt,
  input  logic        faultAct,
  input  logic        cntZero,
  output ctrlStrobe_t strobe,
  output logic        runMode,
  output logic        faultFlag,
  output logic        parkActive
);

  logic flagSet;
  logic hwStop;
  logic zeroHold;
  logic parkOnFault;
  logic parkOnDebug;

  assign flagSet  = runMode && (faultMode != FLT_IGNORE) && faultAct;
  assign hwStop   = runMode && (faultMode == FLT_IMMED) && faultAct;
  assign zeroHold = (faultMode == FLT_AT_ZERO) && (faultFlag || faultAct) && cntZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runMode <= 1'b0;
    end else if (modeWrEn) begin
      runMode <= modeWrData;
    end else if (hwStop) begin
      runMode <= 1'b0;
    end
  end

  // Set beats clear when both land on the same edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultFlag <= 1'b0;
    end else if (flagSet) begin
      faultFlag <= 1'b1;
    end else if (flagClr) begin
      faultFlag <= 1'b0;
    end
  end

  assign parkOnFault = (parkMode == PRK_FAULT || parkMode == PRK_ANY) && faultFlag;
  assign parkOnDebug = (parkMode == PRK_DEBUG || parkMode == PRK_ANY) && dbgHalt;
  assign parkActive  = parkOnFault || parkOnDebug;

  always_comb begin
    strobe.syncEn  = runMode;
    strobe.cntEn   = runMode && !zeroHold;
    strobe.parkSel = parkActive;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    (runMode && faultMode != FLT_IGNORE && faultAct) |=> faultFlag);  // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && faultFlag && runMode && faultMode != FLT_IGNORE && faultAct) |=> faultFlag);  // R3
  AST_IMM_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (runMode && faultMode == FLT_IMMED && faultAct && !modeWrEn) |=> !runMode);  // R4
  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!runMode && !faultFlag) |=> !faultFlag);  // R5
  AST_FLAGONLY_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (runMode && faultMode == FLT_FLAGONLY && !modeWrEn) |=> runMode);  // R7

endmodule

// File: rtl/fault_park_top.sv
module fault_park_top
  import fp_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NUM_CH = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeWrEn,
  input  logic                modeWrData,
  input  logic [1:0]          faultCtl,
  input  logic                faultActLow,
  input  logic                flagClr,
  input  logic [1:0]          parkCtl,
  input  logic [2*NUM_CH-1:0] parkLevels,
  input  logic                faultIn,
  input  logic                dbgHalt,
  input  logic [NUM_CH-1:0]   pwmIn,
  input  logic [NUM_CH-1:0]   pwmCompIn,
  output logic [NUM_CH-1:0]   pwmOut,
  output logic [NUM_CH-1:0]   pwmCompOut,
  output logic                runMode,
  output logic [CNT_W-1:0]    count,
  output logic                faultFlag,
  output logic                parkActive
);

  ctrlStrobe_t strobe;
  logic        faultAct;
  logic        cntZero;

  fp_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .faultMode  (faultMode_t'(faultCtl)),
    .parkMode   (parkMode_t'(parkCtl)),
    .flagClr    (flagClr),
    .dbgHalt    (dbgHalt),
    .faultAct   (faultAct),
    .cntZero    (cntZero),
    .strobe     (strobe),
    .runMode    (runMode),
    .faultFlag  (faultFlag),
    .parkActive (parkActive)
  );

  fp_datapath #(
    .CNT_W  (CNT_W),
    .NUM_CH (NUM_CH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .faultIn     (faultIn),
    .faultActLow (faultActLow),
    .pwmIn       (pwmIn),
    .pwmCompIn   (pwmCompIn),
    .parkLevels  (parkLevels),
    .faultAct    (faultAct),
    .cntZero     (cntZero),
    .count       (count),
    .pwmOut      (pwmOut),
    .pwmCompOut  (pwmCompOut)
  );

  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (runMode && faultCtl == 2'd2 && faultFlag && count == '0) |=> count == '0);  // R6
  AST_PARK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (parkCtl == 2'd0) |-> !parkActive);  // R8

endmodule

// File: tb/test_fault_park_top.sv
`timescale 1ns/1ps
module test_fault_park_top;

  localparam int CNT_W  = 4;
  localparam int NUM_CH = 3;
  localparam int MOD    = 1 << CNT_W;

  logic clk = 0;
  logic rstN = 0;
  logic modeWrEn = 0, modeWrData = 0, faultActLow = 0, flagClr = 0;
  logic [1:0] faultCtl = 0, parkCtl = 0;
  logic [2*NUM_CH-1:0] parkLevels = 0;
  logic faultIn = 0, dbgHalt = 0;
  logic [NUM_CH-1:0] pwmIn = 0, pwmCompIn = 0;
  logic [NUM_CH-1:0] pwmOut, pwmCompOut;
  logic runMode, faultFlag, parkActive;
  logic [CNT_W-1:0] count;

  fault_park_top #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) i_fault_park_top (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .faultCtl(faultCtl), .faultActLow(faultActLow), .flagClr(flagClr),
    .parkCtl(parkCtl), .parkLevels(parkLevels), .faultIn(faultIn),
    .dbgHalt(dbgHalt), .pwmIn(pwmIn), .pwmCompIn(pwmCompIn),
    .pwmOut(pwmOut), .pwmCompOut(pwmCompOut), .runMode(runMode),
    .count(count), .faultFlag(faultFlag), .parkActive(parkActive));

  always #5 clk = ~clk;

  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;
  string phase = "R1 reset";

  // Behavioural reference state
  int mRun = 0, mCnt = 0, mFlag = 0;
  int mPipe[$] = '{0, 0};

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expPark();
    int p = 0;
    if ((parkCtl == 1 || parkCtl == 3) && mFlag == 1) p = 1;
    if ((parkCtl == 2 || parkCtl == 3) && dbgHalt) p = 1;
    return p;
  endfunction

  task automatic compareAll();
    int pk = expPark();
    int eo = 0, ec = 0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      eo += (pk ? parkLevels[2*ch] : pwmIn[ch]) << ch;
      ec += (pk ? parkLevels[2*ch+1] : pwmCompIn[ch]) << ch;
    end
    chk({phase, " count (R10)"}, count, mCnt);
    chk({phase, " runMode (R4)"}, runMode, mRun);
    chk({phase, " faultFlag (R2)"}, faultFlag, mFlag);
    chk({phase, " parkActive (R8)"}, parkActive, pk);
    chk({phase, " pwmOut (R9)"}, pwmOut, eo);
    chk({phase, " pwmCompOut (R9)"}, pwmCompOut, ec);
  endtask

  task automatic tick();
    int fa = mPipe[1];
    int act = (faultIn ^ faultActLow) ? 1 : 0;
    int hold = (faultCtl == 2 && (mFlag == 1 || fa == 1) && mCnt == 0) ? 1 : 0;
    int nCnt = mCnt, nFlag = mFlag, nRun = mRun;
    if (mRun == 1 && hold == 0) nCnt = (mCnt + 1) % MOD;
    if (mRun == 1 && faultCtl != 0 && fa == 1) nFlag = 1;
    else if (flagClr) nFlag = 0;
    if (modeWrEn) nRun = modeWrData;
    else if (faultCtl == 1 && fa == 1 && mRun == 1) nRun = 0;
    @(posedge clk);
    #1;
    if (mRun == 1) begin
      void'(mPipe.pop_back());
      mPipe.push_front(act);
    end
    mCnt = nCnt; mFlag = nFlag; mRun = nRun;
    compareAll();
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic writeRun(bit v);
    modeWrEn = 1; modeWrData = v; tick(); modeWrEn = 0;
  endtask

  task automatic pulseClr();
    flagClr = 1; tick(); flagClr = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nErrors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    pwmIn = 3'b101; pwmCompIn = 3'b010;
    parkLevels = 6'b100110;
    repeat (3) @(posedge clk);
    #1;
    compareAll();
    chk("R1 reset count", count, 0);
    chk("R1 reset runMode", runMode, 0);
    chk("R1 reset pass-through", pwmOut, 3'b101);
    rstN = 1;
    cyc(2);

    phase = "R10 counting";
    writeRun(1);
    cyc(20);
    chk("R10 count after wrap", count, mCnt);

    phase = "R7 flag-only";
    faultCtl = 3;
    faultIn = 1;
    cyc(2);
    chk("R2 flag not yet set after two edges", faultFlag, 0);
    tick();
    chk("R2 flag set on third edge", faultFlag, 1);
    chk("R7 counter still running", runMode, 1);
    phase = "R3 set wins";
    pulseClr();
    chk("R3 set wins over clear", faultFlag, 1);

    phase = "R8 park";
    parkCtl = 1; tick();
    chk("R9 forced outputs", pwmOut, 3'b010);
    chk("R9 forced complements", pwmCompOut, 3'b101);
    faultIn = 0;
    cyc(3);
    pulseClr();
    chk("R3 flag cleared", faultFlag, 0);
    chk("R8 fault park released", parkActive, 0);
    parkCtl = 2; dbgHalt = 1; tick();
    chk("R8 debug park", parkActive, 1);
    parkCtl = 3; cyc(2);
    parkCtl = 1; tick();
    chk("R8 fault-only ignores debug", parkActive, 0);
    parkCtl = 0; dbgHalt = 0; tick();

    phase = "R2 active-low";
    faultIn = 1; faultActLow = 1;
    cyc(4);
    chk("R2 inactive-high line with active-low polarity", faultFlag, 0);
    faultIn = 0;
    cyc(3);
    chk("R2 active-low fault sets flag", faultFlag, 1);
    faultIn = 1;
    cyc(3);
    pulseClr();
    faultActLow = 0; faultIn = 0;
    cyc(3);

    phase = "R4 immediate";
    faultCtl = 1;
    faultIn = 1;
    cyc(4);
    chk("R4 hardware stop", runMode, 0);
    faultIn = 0;
    cyc(2);
    pulseClr();
    phase = "R5 frozen";
    faultIn = 1;
    cyc(6);
    chk("R5 flag stays clear while stopped", faultFlag, 0);
    chk("R5 count held while stopped", count, mCnt);
    faultIn = 0;
    cyc(3);
    phase = "R4 restart";
    faultCtl = 0;
    writeRun(1);
    cyc(3);
    chk("R4 software restart", runMode, 1);
    pulseClr();
    faultCtl = 1;
    cyc(4);

    phase = "R6 stop at zero";
    faultCtl = 2;
    faultIn = 1; cyc(3);
    faultIn = 0;
    cyc(MOD + 4);
    chk("R6 held at zero", count, 0);
    chk("R6 still running", runMode, 1);
    pulseClr();
    cyc(3);
    chk("R6 resumed after clear", count != 0, 1);
    phase = "R6 cancel";
    for (int i = 0; i < MOD && count != 5; i++) tick();
    faultIn = 1; tick(); faultIn = 0;
    cyc(3);
    pulseClr();
    for (int i = 0; i < MOD && count != 0; i++) tick();
    cyc(2);
    chk("R6 passed zero after early clear", count, 2);

    finishRun();
  end

endmodule